// File: doc/BRIEF.md
# Inclusive Directory Snoop Filter

This block is a tag-only directory for a shared last-level cache that sits below several private per-core caches. Each directory entry holds a block tag, a line state (invalid, shared, or modified-owned) and a presence vector with one bit per core. Cores send fill (read), write-upgrade and voluntary eviction notices. The directory updates presence accordingly. When it must replace an entry, it back-invalidates only the cores whose presence bits are set, which keeps the private caches a subset of the directory.

External coherence probes are filtered. A probe for a block the directory does not hold is answered "not present" at once and reaches no core. A probe that hits is forwarded only to the cores that hold the block. Requests are served one at a time. A probe wins over any core request, and core requests go in ascending core index. While back-invalidations are outstanding, the directory takes no new work until every targeted core has acknowledged.

The directory is set-associative. An address splits into a set index in its low bits and a tag above it. Victims are chosen by a tree pseudo-LRU, and an invalid way is always preferred.

Top module: `snoop_filter_top`

## Requirements
- R1: A probe whose block has no valid entry returns `prb_resp_valid`=1 with `prb_resp_hit`=0 and `prb_fwd`=0 in the cycle after `prb_ready`, and raises no `inv_valid`.
- R2: A read request (op code 0) sets the requester's presence bit. If no invalidation is needed, `req_done` pulses for that core alone in the cycle after `req_ready`.
- R3: A probe that hits returns `prb_resp_hit`=1 and `prb_fwd` equal to exactly the block's presence vector (bit i = core i).
- R4: A write request (op code 1) that hits a block other cores hold raises `inv_valid` for exactly those other cores, with `inv_addr` set to the requested block. On completion the presence vector holds only the requester.
- R5: An eviction notice (op code 2) clears only the requester's presence bit. An entry whose vector becomes empty stays valid, so probes still hit it with an empty forward mask. A notice for a block not held leaves the directory unchanged.
- R6: A missing read or write allocates the lowest-numbered invalid way of its set (set = address bits [5:0], tag = the bits above) and raises no invalidation.
- R7: When the set is full, the victim is taken from a tree pseudo-LRU. In that tree a node bit of 0 points to the left (lower) half as least recent, and every hit or allocation by a read or write makes the touched way most recent.
- R8: A victim with a non-empty presence vector raises `inv_valid` for exactly the cores in that vector, with `inv_addr` set to the victim's block address. A victim with an empty vector is replaced with no invalidation.
- R9: Each `inv_valid` bit stays high until that core's `inv_ack`. `req_done` arrives only in the cycle after the last acknowledge. While any invalidation is outstanding, `req_ready` and `prb_ready` stay low.
- R10: At most one grant per cycle. A pending probe is granted before any core request, and among cores the lowest index wins.
- R11: After reset, `inv_valid`, `req_done` and `prb_resp_valid` are low and every probe misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-core request pending |
| req_op | input | 2*N | Per-core op: 0 read, 1 write, 2 eviction notice |
| req_addr | input | ADDR_W*N | Per-core block address |
| req_ready | output | N | Request accepted this cycle |
| req_done | output | N | Request completed (one-cycle pulse) |
| inv_valid | output | N | Back-invalidation pending for each core |
| inv_addr | output | ADDR_W | Block address to invalidate |
| inv_ack | input | N | Per-core invalidation acknowledge |
| prb_valid | input | 1 | External probe pending |
| prb_addr | input | ADDR_W | Probe block address |
| prb_ready | output | 1 | Probe accepted this cycle |
| prb_resp_valid | output | 1 | Probe response valid (one-cycle pulse) |
| prb_resp_hit | output | 1 | Block present in the directory |
| prb_fwd | output | N | Cores the probe is forwarded to |

## Verification
The bench builds the block with its defaults: 4 cores, 64 sets, 4 ways and a 20-bit address. With four ways, five fills into one set fill it completely and force a victim choice. A later notice-then-fill then lands on a way where tree pseudo-LRU and true LRU disagree. With four cores, sharer vectors such as 0101 and 1010 can be built, so targeted invalidation, partial acknowledgement and ascending arbitration among three simultaneous requesters can all be observed at the ports.

// File: rtl/sf_pkg.sv
package sf_pkg;

   typedef enum logic [1:0] {
      OP_RD = 2'd0,
      OP_WR = 2'd1,
      OP_EV = 2'd2
   } req_op_e;

   typedef enum logic [1:0] {
      ST_INV = 2'd0,
      ST_SHR = 2'd1,
      ST_MOD = 2'd2
   } line_state_e;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fsm_e;

endpackage

// File: rtl/sf_arbiter.sv
module sf_arbiter #(
   parameter int N = 4
) (
   input  logic                 en,
   input  logic                 prb_valid,
   input  logic [N-1:0]         req_valid,
   output logic                 prb_grant,
   output logic [N-1:0]         req_grant,
   output logic [$clog2(N)-1:0] req_idx
);
   localparam int CW = $clog2(N);

   logic [N:0] seen;

   assign prb_grant = en & prb_valid;
   assign seen[0]   = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_pri
      assign seen[i+1]    = seen[i] | req_valid[i];
      assign req_grant[i] = en & ~prb_valid & req_valid[i] & ~seen[i];
   end

   always_comb begin
      req_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_valid[i]) req_idx = CW'(i);
      end
   end

endmodule

// File: rtl/sf_plru.sv
module sf_plru #(
   parameter int WAYS = 4
) (
   input  logic [WAYS-2:0]         tree,
   input  logic [$clog2(WAYS)-1:0] touch,
   output logic [$clog2(WAYS)-1:0] victim,
   output logic [WAYS-2:0]         tree_next
);
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS == 2) begin : g_two
      assign victim    = tree[0];
      assign tree_next = ~touch;
   end else begin : g_tree
      always_comb begin
         int node;
         node = 1;
         for (int l = 0; l < WAY_W; l++) begin
            node = node * 2 + int'(tree[node-1]);
         end
         victim = WAY_W'(node - WAYS);
      end

      always_comb begin
         int node;
         int parent;
         tree_next = tree;
         node = int'(touch) + WAYS;
         for (int l = 0; l < WAY_W; l++) begin
            parent = node / 2;
            tree_next[parent-1] = ~node[0];
            node = parent;
         end
      end
   end

endmodule

// File: rtl/sf_dir_array.sv
module sf_dir_array
   import sf_pkg::*;
#(
   parameter int N     = 4,
   parameter int SETS  = 64,
   parameter int WAYS  = 4,
   parameter int TAG_W = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(SETS)-1:0] lk_set,
   input  logic [TAG_W-1:0]        lk_tag,
   output logic                    lk_hit,
   output logic [$clog2(WAYS)-1:0] lk_way,
   output logic [N-1:0]            lk_pres,
   output logic [$clog2(WAYS)-1:0] vic_way,
   output logic                    vic_valid,
   output logic [TAG_W-1:0]        vic_tag,
   output logic [N-1:0]            vic_pres,
   input  logic                    wr_en,
   input  logic [$clog2(WAYS)-1:0] wr_way,
   input  logic [TAG_W-1:0]        wr_tag,
   input  logic [N-1:0]            wr_pres,
   input  line_state_e             wr_state,
   input  logic                    touch_en,
   input  logic [$clog2(WAYS)-1:0] touch_way
);
   localparam int WAY_W = $clog2(WAYS);

   line_state_e        st_q   [SETS][WAYS];
   logic [TAG_W-1:0]   tag_q  [SETS][WAYS];
   logic [N-1:0]       pres_q [SETS][WAYS];
   logic [WAYS-2:0]    tree_q [SETS];

   logic [WAY_W-1:0]   plru_vic;
   logic [WAYS-2:0]    tree_nx;
   logic               any_free;
   logic [WAY_W-1:0]   free_way;

   sf_plru #(.WAYS(WAYS)) u_plru (
      .tree      (tree_q[lk_set]),
      .touch     (touch_way),
      .victim    (plru_vic),
      .tree_next (tree_nx)
   );

   always_comb begin
      lk_hit   = 1'b0;
      lk_way   = '0;
      any_free = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (st_q[lk_set][w] != ST_INV && tag_q[lk_set][w] == lk_tag) begin
            lk_hit = 1'b1;
            lk_way = WAY_W'(w);
         end
         if (st_q[lk_set][w] == ST_INV) begin
            any_free = 1'b1;
            free_way = WAY_W'(w);
         end
      end
      lk_pres   = pres_q[lk_set][lk_way];
      vic_way   = any_free ? free_way : plru_vic;
      vic_valid = st_q[lk_set][vic_way] != ST_INV;
      vic_tag   = tag_q[lk_set][vic_way];
      vic_pres  = pres_q[lk_set][vic_way];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tree_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               st_q[s][w]   <= ST_INV;
               tag_q[s][w]  <= '0;
               pres_q[s][w] <= '0;
            end
         end
      end else begin
         if (wr_en) begin
            st_q[lk_set][wr_way]   <= wr_state;
            tag_q[lk_set][wr_way]  <= wr_tag;
            pres_q[lk_set][wr_way] <= wr_pres;
         end
         if (touch_en) tree_q[lk_set] <= tree_nx;
      end
   end

endmodule

// File: rtl/snoop_filter_top.sv
module snoop_filter_top
   import sf_pkg::*;
#(
   parameter int N      = 4,
   parameter int SETS   = 64,
   parameter int WAYS   = 4,
   parameter int ADDR_W = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          req_valid,
   input  logic [2*N-1:0]        req_op,
   input  logic [ADDR_W*N-1:0]   req_addr,
   output logic [N-1:0]          req_ready,
   output logic [N-1:0]          req_done,
   output logic [N-1:0]          inv_valid,
   output logic [ADDR_W-1:0]     inv_addr,
   input  logic [N-1:0]          inv_ack,
   input  logic                  prb_valid,
   input  logic [ADDR_W-1:0]     prb_addr,
   output logic                  prb_ready,
   output logic                  prb_resp_valid,
   output logic                  prb_resp_hit,
   output logic [N-1:0]          prb_fwd
);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - SET_W;
   localparam int CW    = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("snoop_filter_top: N must be at least 2");
   end
   if (SETS != (1 << SET_W)) begin : g_bad_sets
      $error("snoop_filter_top: SETS must be a power of two");
   end
   if (WAYS < 2 || WAYS != (1 << WAY_W)) begin : g_bad_ways
      $error("snoop_filter_top: WAYS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("snoop_filter_top: ADDR_W must exceed the set index width");
   end

   fsm_e              fs_q;
   logic [N-1:0]      inv_q, done_q, fwd_q;
   logic [ADDR_W-1:0] inv_addr_q;
   logic              resp_v_q, resp_hit_q;
   logic [WAY_W-1:0]  pw_q;
   logic [SET_W-1:0]  ps_q;
   logic [TAG_W-1:0]  pt_q;
   logic [N-1:0]      pp_q;
   line_state_e       pst_q;

   logic              prb_grant;
   logic [N-1:0]      req_grant;
   logic [CW-1:0]     req_idx;
   logic              any_req;
   logic [N-1:0]      req_bit;
   logic [ADDR_W-1:0] cur_addr;
   req_op_e           cur_op;
   logic [SET_W-1:0]  lk_set;
   logic [TAG_W-1:0]  lk_tag;

   logic              lk_hit, vic_valid;
   logic [WAY_W-1:0]  lk_way, vic_way;
   logic [N-1:0]      lk_pres, vic_pres;
   logic [TAG_W-1:0]  vic_tag;

   logic              wr_en, touch_en;
   logic [WAY_W-1:0]  wr_way, touch_way;
   logic [TAG_W-1:0]  wr_tag;
   logic [N-1:0]      wr_pres;
   line_state_e       wr_state;

   logic              start_inv, finish_now;
   logic [N-1:0]      inv_mask, pend_left, others;
   logic [ADDR_W-1:0] inv_a;
   logic [WAY_W-1:0]  pend_way;
   line_state_e       alloc_state;

   sf_arbiter #(.N(N)) u_arb (
      .en        (fs_q == FS_IDLE),
      .prb_valid (prb_valid),
      .req_valid (req_valid),
      .prb_grant (prb_grant),
      .req_grant (req_grant),
      .req_idx   (req_idx)
   );

   assign any_req = |req_grant;
   assign req_bit = any_req ? (N'(1) << req_idx) : '0;

   always_comb begin
      cur_addr = prb_addr;
      cur_op   = OP_RD;
      if (!prb_grant) begin
         cur_addr = req_addr[int'(req_idx)*ADDR_W +: ADDR_W];
         cur_op   = req_op_e'(req_op[int'(req_idx)*2 +: 2]);
      end
   end

   assign lk_set = (fs_q == FS_WAIT) ? ps_q : cur_addr[SET_W-1:0];
   assign lk_tag = cur_addr[ADDR_W-1:SET_W];

   sf_dir_array #(.N(N), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_set    (lk_set),
      .lk_tag    (lk_tag),
      .lk_hit    (lk_hit),
      .lk_way    (lk_way),
      .lk_pres   (lk_pres),
      .vic_way   (vic_way),
      .vic_valid (vic_valid),
      .vic_tag   (vic_tag),
      .vic_pres  (vic_pres),
      .wr_en     (wr_en),
      .wr_way    (wr_way),
      .wr_tag    (wr_tag),
      .wr_pres   (wr_pres),
      .wr_state  (wr_state),
      .touch_en  (touch_en),
      .touch_way (touch_way)
   );

   assign pend_left   = inv_q & ~inv_ack;
   assign others      = lk_pres & ~req_bit;
   assign alloc_state = (cur_op == OP_WR) ? ST_MOD : ST_SHR;
   assign pend_way    = lk_hit ? lk_way : vic_way;

   always_comb begin
      wr_en      = 1'b0;
      wr_way     = lk_way;
      wr_tag     = lk_tag;
      wr_pres    = '0;
      wr_state   = ST_SHR;
      touch_en   = 1'b0;
      touch_way  = lk_way;
      start_inv  = 1'b0;
      finish_now = 1'b0;
      inv_mask   = '0;
      inv_a      = cur_addr;
      if (fs_q == FS_WAIT) begin
         if (pend_left == '0) begin
            wr_en     = 1'b1;
            wr_way    = pw_q;
            wr_tag    = pt_q;
            wr_pres   = pp_q;
            wr_state  = pst_q;
            touch_en  = 1'b1;
            touch_way = pw_q;
         end
      end else if (any_req) begin
         if (cur_op == OP_EV) begin
            finish_now = 1'b1;
            if (lk_hit) begin
               wr_en   = 1'b1;
               wr_pres = others;
            end
         end else if (lk_hit) begin
            if (cur_op == OP_WR && others != '0) begin
               start_inv = 1'b1;
               inv_mask  = others;
            end else begin
               finish_now = 1'b1;
               wr_en      = 1'b1;
               wr_pres    = (cur_op == OP_WR) ? req_bit : (lk_pres | req_bit);
               wr_state   = alloc_state;
               touch_en   = 1'b1;
            end
         end else if (vic_valid && vic_pres != '0) begin
            start_inv = 1'b1;
            inv_mask  = vic_pres;
            inv_a     = {vic_tag, lk_set};
         end else begin
            finish_now = 1'b1;
            wr_en      = 1'b1;
            wr_way     = vic_way;
            wr_pres    = req_bit;
            wr_state   = alloc_state;
            touch_en   = 1'b1;
            touch_way  = vic_way;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q       <= FS_IDLE;
         inv_q      <= '0;
         inv_addr_q <= '0;
         done_q     <= '0;
         resp_v_q   <= 1'b0;
         resp_hit_q <= 1'b0;
         fwd_q      <= '0;
         pw_q       <= '0;
         ps_q       <= '0;
         pt_q       <= '0;
         pp_q       <= '0;
         pst_q      <= ST_INV;
      end else begin
         done_q   <= '0;
         resp_v_q <= 1'b0;
         if (prb_grant) begin
            resp_v_q   <= 1'b1;
            resp_hit_q <= lk_hit;
            fwd_q      <= lk_hit ? lk_pres : '0;
         end
         if (fs_q == FS_IDLE) begin
            if (start_inv) begin
               fs_q       <= FS_WAIT;
               inv_q      <= inv_mask;
               inv_addr_q <= inv_a;
               pw_q       <= pend_way;
               ps_q       <= lk_set;
               pt_q       <= lk_tag;
               pp_q       <= req_bit;
               pst_q      <= alloc_state;
            end
            if (finish_now) done_q <= req_bit;
         end else begin
            inv_q <= pend_left;
            if (pend_left == '0) begin
               fs_q   <= FS_IDLE;
               done_q <= pp_q;
            end
         end
      end
   end

   assign req_ready      = req_grant;
   assign prb_ready      = prb_grant;
   assign req_done       = done_q;
   assign inv_valid      = inv_q;
   assign inv_addr       = inv_addr_q;
   assign prb_resp_valid = resp_v_q;
   assign prb_resp_hit   = resp_hit_q;
   assign prb_fwd        = fwd_q;

endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
   parameter int N      = 4,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      req_valid,
   input logic [N-1:0]      req_ready,
   input logic [N-1:0]      req_done,
   input logic [N-1:0]      inv_valid,
   input logic [ADDR_W-1:0] inv_addr,
   input logic [N-1:0]      inv_ack,
   input logic              prb_valid,
   input logic              prb_ready,
   input logic              prb_resp_valid,
   input logic              prb_resp_hit,
   input logic [N-1:0]      prb_fwd
);

   a_r1_miss_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_resp_valid && !prb_resp_hit) |-> (prb_fwd == '0));

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_done));

   a_r9_stall_while_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid != '0) |-> (req_ready == '0 && !prb_ready));

   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid != '0 && $past(inv_valid) != '0) |-> $stable(inv_addr));

   a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, prb_ready}));

   a_r10_probe_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready != '0) |-> !prb_valid);

   for (genvar i = 0; i < N; i++) begin : g_core
      a_r9_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (inv_valid[i] && !inv_ack[i]) |=> inv_valid[i]);

      a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
         (inv_valid[i] && inv_ack[i]) |=> !inv_valid[i]);

      a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
         req_ready[i] |-> ((req_valid & ((N'(1) << i) - N'(1))) == '0));

      a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
         req_ready[i] |-> req_valid[i]);
   end

endmodule

bind snoop_filter_top sf_checker #(.N(N), .ADDR_W(ADDR_W)) u_sf_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_done       (req_done),
   .inv_valid      (inv_valid),
   .inv_addr       (inv_addr),
   .inv_ack        (inv_ack),
   .prb_valid      (prb_valid),
   .prb_ready      (prb_ready),
   .prb_resp_valid (prb_resp_valid),
   .prb_resp_hit   (prb_resp_hit),
   .prb_fwd        (prb_fwd)
);

// File: tb/snoop_filter_top_tb_top.sv
`timescale 1ns/1ps
module snoop_filter_top_tb_top;
   localparam int N  = 4;
   localparam int AW = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [2*N-1:0]  req_op = '0;
   logic [AW*N-1:0] req_addr = '0;
   logic [N-1:0]    req_ready, req_done, inv_valid, prb_fwd;
   logic [AW-1:0]   inv_addr;
   logic [N-1:0]    inv_ack = '0;
   logic            prb_valid = 1'b0;
   logic [AW-1:0]   prb_addr = '0;
   logic            prb_ready, prb_resp_valid, prb_resp_hit;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   snoop_filter_top #(.N(N), .SETS(64), .WAYS(4), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_ready(req_ready), .req_done(req_done),
      .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
      .prb_valid(prb_valid), .prb_addr(prb_addr), .prb_ready(prb_ready),
      .prb_resp_valid(prb_resp_valid), .prb_resp_hit(prb_resp_hit), .prb_fwd(prb_fwd)
   );

   typedef struct packed {
      logic        is_probe;
      logic [1:0]  core;
      logic [1:0]  op;
      logic [19:0] addr;
      logic        exp_hit;
      logic [3:0]  exp_mask;
   } vec_t;

   // A = tag 1 set 1, B = tag 2 set 2, C = tag 3 set 3
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd0, 2'd0, 20'h00041, 1'b0, 4'h0},  // R1 probe miss on empty
      '{1'b0, 2'd0, 2'd0, 20'h00041, 1'b0, 4'h0},  // R2 core0 reads A
      '{1'b1, 2'd0, 2'd0, 20'h00041, 1'b1, 4'h1},  // R3
      '{1'b0, 2'd2, 2'd0, 20'h00041, 1'b0, 4'h0},  // R2 core2 reads A
      '{1'b1, 2'd0, 2'd0, 20'h00041, 1'b1, 4'h5},  // R3
      '{1'b0, 2'd2, 2'd2, 20'h00041, 1'b0, 4'h0},  // R5 core2 drops A
      '{1'b1, 2'd0, 2'd0, 20'h00041, 1'b1, 4'h1},  // R5
      '{1'b0, 2'd0, 2'd2, 20'h00041, 1'b0, 4'h0},  // R5 core0 drops A
      '{1'b1, 2'd0, 2'd0, 20'h00041, 1'b1, 4'h0},  // R5 empty entry still hits
      '{1'b0, 2'd1, 2'd1, 20'h00082, 1'b0, 4'h0},  // R6 core1 writes B
      '{1'b1, 2'd0, 2'd0, 20'h00082, 1'b1, 4'h2},  // R3
      '{1'b0, 2'd3, 2'd2, 20'h000C3, 1'b0, 4'h0},  // R5 notice for absent C
      '{1'b1, 2'd0, 2'd0, 20'h000C3, 1'b0, 4'h0},  // R5 C still absent
      '{1'b0, 2'd3, 2'd0, 20'h00082, 1'b0, 4'h0}   // R2 core3 reads B
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send_req(input int c, input logic [1:0] op, input logic [AW-1:0] a);
      int k;
      @(negedge clk);
      req_valid[c] = 1'b1;
      req_op[c*2 +: 2] = op;
      req_addr[c*AW +: AW] = a;
      k = 0;
      #1;
      while (!req_ready[c] && k < 100) begin
         @(negedge clk); #1; k++;
      end
      @(posedge clk);
      @(negedge clk);
      req_valid[c] = 1'b0;
      #1;
   endtask

   task automatic send_probe(input logic [AW-1:0] a);
      int k;
      @(negedge clk);
      prb_valid = 1'b1;
      prb_addr = a;
      k = 0;
      #1;
      while (!prb_ready && k < 100) begin
         @(negedge clk); #1; k++;
      end
      @(posedge clk);
      @(negedge clk);
      prb_valid = 1'b0;
      #1;
   endtask

   task automatic expect_probe(input string req, input logic a_hit, input logic [N-1:0] mask);
      check(prb_resp_valid == 1'b1, req, "probe resp valid", 32'(prb_resp_valid), 32'd1);
      check(prb_resp_hit == a_hit, req, "probe hit", 32'(prb_resp_hit), 32'(a_hit));
      check(prb_fwd == mask, req, "probe forward", 32'(prb_fwd), 32'(mask));
   endtask

   task automatic ack(input int c);
      @(negedge clk);
      inv_ack[c] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inv_ack[c] = 1'b0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      check(inv_valid == '0, "R11", "inv_valid", 32'(inv_valid), 0);
      check(req_done == '0, "R11", "req_done", 32'(req_done), 0);
      check(prb_resp_valid == 1'b0, "R11", "resp_valid", 32'(prb_resp_valid), 0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_probe) begin
            send_probe(VECS[i].addr);
            expect_probe(VECS[i].exp_hit ? "R3" : "R1", VECS[i].exp_hit, VECS[i].exp_mask);
            check(inv_valid == '0, "R1", "no inv on probe", 32'(inv_valid), 0);
         end else begin
            send_req(int'(VECS[i].core), VECS[i].op, VECS[i].addr);
            check(req_done == (N'(1) << VECS[i].core), (VECS[i].op == 2'd2) ? "R5" : "R2",
                  "done", 32'(req_done), 32'(N'(1) << VECS[i].core));
            check(inv_valid == '0, "R6", "no inv", 32'(inv_valid), 0);
         end
      end
      send_probe(20'h00082);
      expect_probe("R3", 1'b1, 4'b1010);

      // R4 upgrade with sharer, plus R9 stall and R10 ordering
      send_req(1, 2'd1, 20'h00082);
      check(inv_valid == 4'b1000, "R4", "upgrade inv mask", 32'(inv_valid), 32'h8);
      check(inv_addr == 20'h00082, "R4", "upgrade inv addr", 32'(inv_addr), 32'h82);
      check(req_done == '0, "R9", "no done before ack", 32'(req_done), 0);
      req_valid[0] = 1'b1; req_op[1:0] = 2'd0; req_addr[0 +: AW] = 20'h00104;
      req_valid[2] = 1'b1; req_op[5:4] = 2'd0; req_addr[2*AW +: AW] = 20'h00145;
      prb_valid = 1'b1; prb_addr = 20'h00082;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         check(req_ready == '0 && !prb_ready, "R9", "stall grants", 32'({req_ready, prb_ready}), 0);
         check(inv_valid == 4'b1000, "R9", "inv held", 32'(inv_valid), 32'h8);
      end
      ack(3);
      check(req_done == 4'b0010, "R4", "upgrade done", 32'(req_done), 32'h2);
      check(inv_valid == '0, "R9", "inv cleared", 32'(inv_valid), 0);
      check(prb_ready == 1'b1 && req_ready == '0, "R10", "probe first",
            32'({req_ready, prb_ready}), 32'h1);
      @(posedge clk); @(negedge clk);
      prb_valid = 1'b0;
      #1;
      expect_probe("R4", 1'b1, 4'b0010);
      check(req_ready == 4'b0001, "R10", "core0 next", 32'(req_ready), 32'h1);
      @(posedge clk); @(negedge clk);
      req_valid[0] = 1'b0;
      #1;
      check(req_done == 4'b0001, "R10", "core0 done", 32'(req_done), 32'h1);
      check(req_ready == 4'b0100, "R10", "core2 next", 32'(req_ready), 32'h4);
      @(posedge clk); @(negedge clk);
      req_valid[2] = 1'b0;
      #1;
      check(req_done == 4'b0100, "R10", "core2 done", 32'(req_done), 32'h4);

      // R6/R7/R8 set 9: tags 10..15
      send_req(0, 2'd0, 20'h00289);
      send_req(2, 2'd0, 20'h00289);
      send_req(1, 2'd0, 20'h002C9);
      send_req(2, 2'd0, 20'h00309);
      send_req(3, 2'd0, 20'h00349);
      check(req_done == 4'b1000 && inv_valid == '0, "R6", "fourth way fill",
            32'({req_done, inv_valid}), 32'h80);
      send_req(1, 2'd0, 20'h00389);
      check(inv_valid == 4'b0101, "R8", "victim inv mask", 32'(inv_valid), 32'h5);
      check(inv_addr == 20'h00289, "R8", "victim inv addr", 32'(inv_addr), 32'h289);
      ack(0);
      check(inv_valid == 4'b0100, "R9", "partial ack", 32'(inv_valid), 32'h4);
      check(req_done == '0, "R9", "no done on partial", 32'(req_done), 0);
      ack(2);
      check(req_done == 4'b0010, "R9", "done after last ack", 32'(req_done), 32'h2);
      send_probe(20'h00289);
      expect_probe("R8", 1'b0, 4'b0000);
      send_probe(20'h00389);
      expect_probe("R7", 1'b1, 4'b0010);
      send_req(2, 2'd2, 20'h00309);
      send_req(3, 2'd0, 20'h003C9);
      check(inv_valid == '0, "R8", "empty victim no inv", 32'(inv_valid), 0);
      check(req_done == 4'b1000, "R8", "empty victim done", 32'(req_done), 32'h8);
      send_probe(20'h00309);
      expect_probe("R7", 1'b0, 4'b0000);
      send_probe(20'h002C9);
      expect_probe("R7", 1'b1, 4'b0010);
      send_probe(20'h003C9);
      expect_probe("R7", 1'b1, 4'b1000);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule